// File: doc/BRIEF.md
# Chained Double-Buffered DMA Channel

This block is one DMA channel engine. Software programs an active segment (a running address and an end address) and, optionally, a queued follow-on segment (a begin and an end address). While enabled, the channel asks a single memory port for one 32-bit word at a time at the running address. Each grant moves one word between the memory port and a device stream and steps the address by four. When the running address meets the end, the channel flags completion and raises its interrupt. It then either swaps the queued segment in, if software armed the one-shot chain flag, or it stops.

Every address register has its own saved copy at a separate index. The saved end copy is written by hardware with the address at which a segment actually finished, so a transfer cut short by a memory error can be measured. A build option for transmit channels treats bit 31 of the end address as a marker: the real end is then that address with bit 31 cleared, minus 15. The device stream is assumed always ready: a word is offered to it, or taken from it, in the same cycle as the memory grant.

Top module: `dmac_channel`

## Requirements
- R1: Register indices are 1 = running address, 2 = end address, 3 = queued begin, 4 = queued end, 5..8 = saved copies of 1..4. Each is written by a register write at its index and read back through `reg_rdata`. Writing one index leaves the others unchanged.
- R2: A write to index 0 (control) acts as commands: bit0 enable, bit1 arm chain, bit2 select memory-read direction, bit3 select memory-write direction, bit4 clear completion, bit5 channel reset, bit6 buffer init. Reading index 0 gives status: bit0 enabled, bit1 chain armed, bit2 memory-read direction, bit3 complete, bit4 bus error. Writing zero to index 0 changes no status bit.
- R3: A control write with channel reset and clear completion both set leaves enabled, chain armed and complete all reading zero.
- R4: `mem_req` is high only while enabled and the running address differs from the effective end. `mem_addr` is the running address, and each granted word without error adds 4 to it.
- R5: One cycle after the running address meets the effective end, the complete bit and `irq` are set. Clear completion drops both.
- R6: If the chain flag is armed at completion, the queued begin and end go into the running and end registers, the chain flag clears and the channel stays enabled.
- R7: If the chain flag is clear at completion, the channel disables and requests stop.
- R8: At every completion the saved end copy (index 6) receives the running address at which the segment ended.
- R9: A grant with `mem_err` high sets the bus-error bit and ends the segment at the unadvanced address, with complete set. Enable is kept if the chain flag was armed.
- R10: With `TX_MODE`=1 and bit 31 of the end address set, the effective end is the end with bit 31 cleared, minus 15. With `TX_MODE`=0 the end address is used as written.
- R11: The direction bit reads back in status and sets `mem_we`: memory-write direction drives `mem_we` high and memory-read drives it low.
- R12: Arming the chain flag while a completion is still pending (complete set) makes the next completion chain.
- R13: Buffer init sets all eight address registers to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on index) |
| mem_req | output | 1 | Memory word request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory word address |
| mem_wdata | output | 32 | Data to memory (from device stream) |
| mem_rdata | input | 32 | Data from memory |
| mem_gnt | input | 1 | Memory grant for the current request |
| mem_err | input | 1 | Memory error with the grant |
| dev_wdata | input | 32 | Device word headed for memory |
| dev_wtake | output | 1 | Device word consumed this cycle |
| dev_rdata | output | 32 | Memory word headed for device |
| dev_rvalid | output | 1 | `dev_rdata` valid this cycle |
| irq | output | 1 | Completion interrupt |

## Verification
Register writes take effect at the clock edge that samples the strobe, and the status is readable at the falling edge after it. A granted word moves the address at the edge that samples the grant. Completion, chaining and stopping land one edge after the address reaches the end, so a segment of n words completes n+1 edges after the enabling write. The bench holds the grant high and counts falling edges from the write that enabled the channel. It checks each result at exactly that edge and never polls.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  localparam int DW        = 32;
  localparam int IDX_W     = 4;
  localparam int N_AREGS   = 8;

  // register indices (0 is control/status)
  localparam logic [IDX_W-1:0] IX_CTRL = 4'd0;

  // address register slots inside the register array
  localparam int SL_RUN    = 0;
  localparam int SL_END    = 1;
  localparam int SL_QBEG   = 2;
  localparam int SL_QEND   = 3;
  localparam int SL_SV_RUN = 4;
  localparam int SL_SV_END = 5;

  // command bit positions of a control write
  localparam int CB_EN     = 0;
  localparam int CB_ARM    = 1;
  localparam int CB_RD     = 2;
  localparam int CB_WR     = 3;
  localparam int CB_CLR    = 4;
  localparam int CB_RST    = 5;
  localparam int CB_INIT   = 6;

  typedef struct packed {
    logic init_buf;
    logic chan_rst;
    logic clr_done;
    logic sel_wr;
    logic sel_rd;
    logic arm;
    logic enable;
  } cmd_t;

  typedef struct packed {
    logic buserr;
    logic done;
    logic dir_rd;
    logic armed;
    logic en;
  } stat_t;

  // effective end of a segment
  function automatic logic [DW-1:0] eff_end(input logic [DW-1:0] lim, input logic tx);
    if (tx && lim[DW-1])
      return {1'b0, lim[DW-2:0]} - DW'(15);
    return lim;
  endfunction

  function automatic logic [DW-1:0] step_addr(input logic [DW-1:0] a, input int unsigned st);
    return a + DW'(st);
  endfunction
endpackage

// File: rtl/dmac_cmd_decode.sv
module dmac_cmd_decode
  import dmac_pkg::*;
(
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     idx,
  input  logic [DW-1:0]        wdata,
  output cmd_t                 cmd,
  output logic [N_AREGS-1:0]   areg_wr
);
  logic ctrl_hit;
  assign ctrl_hit = wr_en && (idx == IX_CTRL);

  always_comb begin
    cmd.enable   = ctrl_hit & wdata[CB_EN];
    cmd.arm      = ctrl_hit & wdata[CB_ARM];
    cmd.sel_rd   = ctrl_hit & wdata[CB_RD];
    cmd.sel_wr   = ctrl_hit & wdata[CB_WR];
    cmd.clr_done = ctrl_hit & wdata[CB_CLR];
    cmd.chan_rst = ctrl_hit & wdata[CB_RST];
    cmd.init_buf = ctrl_hit & wdata[CB_INIT];
  end

  for (genvar g = 0; g < N_AREGS; g++) begin : g_sel
    assign areg_wr[g] = wr_en && (idx == IDX_W'(g + 1));
  end
endmodule

// File: rtl/dmac_addr_regs.sv
module dmac_addr_regs
  import dmac_pkg::*;
#(
  parameter int unsigned STEP = 4
)(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [N_AREGS-1:0]            areg_wr,
  input  logic [DW-1:0]                 wdata,
  input  logic                          init_buf,
  input  logic                          advance,
  input  logic                          chain,
  input  logic                          finish,
  output logic [N_AREGS-1:0][DW-1:0]    regs_q
);
  logic [N_AREGS-1:0][DW-1:0] hw_d;

  always_comb begin
    hw_d = regs_q;
    if (advance)
      hw_d[SL_RUN] = step_addr(regs_q[SL_RUN], STEP);
    if (chain) begin
      hw_d[SL_RUN]    = regs_q[SL_QBEG];
      hw_d[SL_END]    = regs_q[SL_QEND];
      hw_d[SL_SV_RUN] = regs_q[SL_QBEG];
    end
    if (finish)
      hw_d[SL_SV_END] = regs_q[SL_RUN];
  end

  for (genvar g = 0; g < N_AREGS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          regs_q[g] <= '0;
      else if (init_buf)   regs_q[g] <= '0;
      else if (areg_wr[g]) regs_q[g] <= wdata;
      else                 regs_q[g] <= hw_d[g];
    end
  end

  p_adv_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !areg_wr[SL_RUN] && !init_buf) |=> regs_q[SL_RUN] == $past(regs_q[SL_RUN]) + DW'(STEP));

  p_chain_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (chain && !areg_wr[SL_RUN] && !areg_wr[SL_END] && !init_buf)
      |=> (regs_q[SL_RUN] == $past(regs_q[SL_QBEG])) && (regs_q[SL_END] == $past(regs_q[SL_QEND])));

  p_saved_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && !areg_wr[SL_SV_END] && !init_buf) |=> regs_q[SL_SV_END] == $past(regs_q[SL_RUN]));

  p_init_zero_r13: assert property (@(posedge clk) disable iff (!rst_n)
    init_buf |=> (regs_q[SL_RUN] == '0) && (regs_q[SL_QEND] == '0));
endmodule

// File: rtl/dmac_status.sv
module dmac_status
  import dmac_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  cmd_t  cmd,
  input  logic  finish,
  input  logic  err_evt,
  output stat_t st_q,
  output logic  chain,
  output logic  halt
);
  logic hw_live;
  assign hw_live = !cmd.chan_rst;
  assign chain   = finish & st_q.armed;
  assign halt    = finish & ~st_q.armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
    end else begin
      if (cmd.chan_rst)    st_q.en <= 1'b0;
      else if (cmd.enable) st_q.en <= 1'b1;
      else if (halt)       st_q.en <= 1'b0;

      if (cmd.chan_rst)    st_q.armed <= 1'b0;
      else if (cmd.arm)    st_q.armed <= 1'b1;
      else if (chain)      st_q.armed <= 1'b0;

      if (cmd.chan_rst)    st_q.dir_rd <= 1'b0;
      else if (cmd.sel_rd) st_q.dir_rd <= 1'b1;
      else if (cmd.sel_wr) st_q.dir_rd <= 1'b0;

      if (finish && hw_live) st_q.done <= 1'b1;
      else if (cmd.clr_done) st_q.done <= 1'b0;

      if (err_evt && hw_live) st_q.buserr <= 1'b1;
      else if (cmd.clr_done)  st_q.buserr <= 1'b0;
    end
  end

  p_quiet_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd == '0) && !finish && !err_evt) |=> $stable(st_q));

  p_rst_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.chan_rst && cmd.clr_done) |=> (!st_q.en && !st_q.armed && !st_q.done));

  p_done_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && !cmd.chan_rst) |=> st_q.done);

  p_halt_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !cmd.enable) |=> !st_q.en);

  p_err_keeps_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (err_evt && st_q.armed && !cmd.chan_rst) |=> (st_q.en && st_q.buserr));

  p_pend_chain_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && st_q.armed && st_q.done && !cmd.chan_rst && !cmd.arm) |=> (st_q.en && !st_q.armed));
endmodule

// File: rtl/dmac_channel.sv
module dmac_channel
  import dmac_pkg::*;
#(
  parameter int unsigned STEP    = 4,
  parameter bit          TX_MODE = 1'b0
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [3:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic             mem_req,
  output logic             mem_we,
  output logic [31:0]      mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic [31:0]      mem_rdata,
  input  logic             mem_gnt,
  input  logic             mem_err,
  input  logic [31:0]      dev_wdata,
  output logic             dev_wtake,
  output logic [31:0]      dev_rdata,
  output logic             dev_rvalid,
  output logic             irq
);
  cmd_t                       cmd;
  stat_t                      st_q;
  logic [N_AREGS-1:0]         areg_wr;
  logic [N_AREGS-1:0][DW-1:0] regs_q;

  // named internal events
  logic [DW-1:0] end_addr;
  logic          at_end;
  logic          gnt_evt;
  logic          err_evt;
  logic          advance;
  logic          seg_end;
  logic          finish;
  logic          chain;
  logic          halt;

  dmac_cmd_decode u_dec (
    .wr_en   (reg_we),
    .idx     (reg_addr),
    .wdata   (reg_wdata),
    .cmd     (cmd),
    .areg_wr (areg_wr)
  );

  assign end_addr = eff_end(regs_q[SL_END], TX_MODE);
  assign at_end   = (regs_q[SL_RUN] == end_addr);
  assign mem_req  = st_q.en && !at_end;
  assign gnt_evt  = mem_req && mem_gnt;
  assign err_evt  = gnt_evt && mem_err;
  assign advance  = gnt_evt && !mem_err;
  assign seg_end  = st_q.en && at_end;
  assign finish   = seg_end || err_evt;

  dmac_status u_stat (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmd     (cmd),
    .finish  (finish),
    .err_evt (err_evt),
    .st_q    (st_q),
    .chain   (chain),
    .halt    (halt)
  );

  dmac_addr_regs #(.STEP(STEP)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .areg_wr  (areg_wr),
    .wdata    (reg_wdata),
    .init_buf (cmd.init_buf),
    .advance  (advance),
    .chain    (chain),
    .finish   (finish),
    .regs_q   (regs_q)
  );

  assign mem_we     = !st_q.dir_rd;
  assign mem_addr   = regs_q[SL_RUN];
  assign mem_wdata  = dev_wdata;
  assign dev_rdata  = mem_rdata;
  assign dev_wtake  = advance && !st_q.dir_rd;
  assign dev_rvalid = advance && st_q.dir_rd;
  assign irq        = st_q.done;

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == IX_CTRL)
      reg_rdata = {{(DW-5){1'b0}}, st_q.buserr, st_q.done, st_q.dir_rd, st_q.armed, st_q.en};
    for (int i = 0; i < N_AREGS; i++)
      if (reg_addr == IDX_W'(i + 1))
        reg_rdata = regs_q[i];
  end

  p_req_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !cmd.enable) |=> !mem_req);

  p_irq_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.clr_done && !finish) |=> !irq);

  p_one_way_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(dev_wtake && dev_rvalid));
endmodule

// File: tb/tb_dmac_channel.sv
module tb_dmac_channel;
  localparam int CLK_P = 10;
  localparam logic [31:0] C_EN = 32'h01, C_ARM = 32'h02, C_RD = 32'h04, C_WR = 32'h08,
                          C_CLR = 32'h10, C_RST = 32'h20, C_INIT = 32'h40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic mem_gnt = 1'b0, mem_err = 1'b0;
  logic [31:0] mem_rdata = 32'hA5A5_0000, dev_wdata = 32'h5A5A_0000;

  logic [31:0] reg_rdata, mem_addr, mem_wdata, dev_rdata;
  logic mem_req, mem_we, dev_wtake, dev_rvalid, irq;
  logic [31:0] t_rdata, t_addr, t_wdata, t_drdata;
  logic t_req, t_we, t_wtake, t_rvalid, t_irq;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  dmac_channel dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_gnt(mem_gnt), .mem_err(mem_err),
    .dev_wdata(dev_wdata), .dev_wtake(dev_wtake), .dev_rdata(dev_rdata),
    .dev_rvalid(dev_rvalid), .irq(irq));

  dmac_channel #(.TX_MODE(1'b1)) dut_tx (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(t_rdata), .mem_req(t_req), .mem_we(t_we), .mem_addr(t_addr),
    .mem_wdata(t_wdata), .mem_rdata(mem_rdata), .mem_gnt(mem_gnt), .mem_err(mem_err),
    .dev_wdata(dev_wdata), .dev_wtake(t_wtake), .dev_rdata(t_drdata),
    .dev_rvalid(t_rvalid), .irq(t_irq));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d, output logic [31:0] dt);
    reg_addr = a;
    #1;
    d = reg_rdata;
    dt = t_rdata;
  endtask

  // start sequence; the last write (enable) is edge E, returns at the negedge after E
  task automatic start_seg(input logic [31:0] dir, input logic [31:0] run, input logic [31:0] lim,
                           input logic [31:0] qb, input logic [31:0] qe, input logic [31:0] go);
    wr(4'd0, C_RST | C_CLR | C_INIT | dir);
    wr(4'd0, 32'h0);
    wr(4'd1, run); wr(4'd2, lim); wr(4'd3, qb); wr(4'd4, qe);
    wr(4'd0, go | dir);
  endtask

  task automatic t_reset_state();
    logic [31:0] v, vt;
    rd(4'd0, v, vt);
    chk("R2 reset status", v, 32'h0);
    chk("R5 reset irq", {31'b0, irq}, 32'h0);
    chk("R4 reset req", {31'b0, mem_req}, 32'h0);
  endtask

  task automatic t_regfile();
    logic [31:0] v, vt;
    for (int i = 1; i <= 8; i++) wr(4'(i), 32'h1000_0000 + 32'(i) * 32'h11);
    for (int i = 1; i <= 8; i++) begin
      rd(4'(i), v, vt);
      chk($sformatf("R1 reg %0d", i), v, 32'h1000_0000 + 32'(i) * 32'h11);
    end
    wr(4'd0, C_INIT);
    for (int i = 1; i <= 8; i++) begin
      rd(4'(i), v, vt);
      chk($sformatf("R13 init reg %0d", i), v, 32'h0);
    end
  endtask

  task automatic t_zero_and_dir();
    logic [31:0] v, vt;
    wr(4'd0, C_ARM | C_RD);
    wr(4'd0, 32'h0);
    rd(4'd0, v, vt);
    chk("R2 zero write keeps status", v, 32'h6);
    chk("R11 read dir mem_we", {31'b0, mem_we}, 32'h0);
    wr(4'd0, C_WR);
    rd(4'd0, v, vt);
    chk("R11 write dir status", v & 32'h4, 32'h0);
    chk("R11 write dir mem_we", {31'b0, mem_we}, 32'h1);
  endtask

  task automatic t_chained();
    logic [31:0] v, vt;
    mem_gnt = 1'b1;
    start_seg(C_RD, 32'h100, 32'h110, 32'h200, 32'h208, C_EN | C_ARM);
    rd(4'd0, v, vt);
    chk("R4 req when enabled", {31'b0, mem_req}, 32'h1);
    chk("R11 read dir rvalid", {31'b0, dev_rvalid}, 32'h1);
    repeat (4) @(negedge clk);
    rd(4'd1, v, vt);
    chk("R4 four words stepped", v, 32'h110);
    chk("R5 not done before end", {31'b0, irq}, 32'h0);
    @(negedge clk);
    chk("R5 irq after end", {31'b0, irq}, 32'h1);
    rd(4'd0, v, vt);
    chk("R6 chained status", v, 32'h0D);
    rd(4'd1, v, vt);  chk("R6 run loaded", v, 32'h200);
    rd(4'd2, v, vt);  chk("R6 end loaded", v, 32'h208);
    rd(4'd6, v, vt);  chk("R8 saved end first", v, 32'h110);
    repeat (3) @(negedge clk);
    rd(4'd0, v, vt);
    chk("R7 stopped status", v, 32'h0C);
    chk("R7 no request", {31'b0, mem_req}, 32'h0);
    rd(4'd6, v, vt);  chk("R8 saved end second", v, 32'h208);
    wr(4'd0, C_CLR);
    chk("R5 clear drops irq", {31'b0, irq}, 32'h0);
    mem_gnt = 1'b0;
  endtask

  task automatic t_unchained();
    logic [31:0] v, vt;
    mem_gnt = 1'b1;
    start_seg(C_WR, 32'h300, 32'h308, 32'h0, 32'h0, C_EN);
    chk("R11 write dir take", {31'b0, dev_wtake}, 32'h1);
    repeat (3) @(negedge clk);
    rd(4'd0, v, vt);
    chk("R7 single segment stop", v, 32'h08);
    chk("R7 request low", {31'b0, mem_req}, 32'h0);
    rd(4'd1, v, vt);
    chk("R7 run held at end", v, 32'h308);
    wr(4'd0, C_RST | C_CLR);
    rd(4'd0, v, vt);
    chk("R3 reset with clear", v, 32'h0);
    mem_gnt = 1'b0;
  endtask

  task automatic t_buserr();
    logic [31:0] v, vt;
    mem_gnt = 1'b1;
    start_seg(C_WR, 32'h400, 32'h410, 32'h500, 32'h504, C_EN | C_ARM);
    @(negedge clk);
    mem_err = 1'b1;
    @(negedge clk);
    mem_err = 1'b0;
    rd(4'd0, v, vt);
    chk("R9 error status en kept", v, 32'h19);
    rd(4'd6, v, vt);  chk("R9 short end recorded", v, 32'h404);
    rd(4'd1, v, vt);  chk("R9 chained after error", v, 32'h500);
    repeat (2) @(negedge clk);
    rd(4'd0, v, vt);
    chk("R9 stops after queued", v, 32'h18);
    mem_gnt = 1'b0;
  endtask

  task automatic t_pending_arm();
    logic [31:0] v, vt;
    mem_gnt = 1'b1;
    start_seg(C_WR, 32'h600, 32'h604, 32'h700, 32'h704, C_EN | C_ARM);
    @(negedge clk);
    @(negedge clk);
    mem_gnt = 1'b0;
    rd(4'd0, v, vt);
    chk("R12 first chain pending", v, 32'h09);
    wr(4'd3, 32'h800); wr(4'd4, 32'h808);
    wr(4'd0, C_ARM);
    mem_gnt = 1'b1;
    repeat (2) @(negedge clk);
    rd(4'd1, v, vt);  chk("R12 chained with pending done", v, 32'h800);
    rd(4'd0, v, vt);  chk("R12 status after chain", v, 32'h09);
    repeat (3) @(negedge clk);
    rd(4'd0, v, vt);  chk("R12 final stop", v, 32'h08);
    mem_gnt = 1'b0;
  endtask

  task automatic t_txmode();
    logic [31:0] v, vt;
    mem_gnt = 1'b1;
    start_seg(C_RD, 32'h0, 32'h8000_001F, 32'h0, 32'h0, C_EN);
    repeat (5) @(negedge clk);
    rd(4'd0, v, vt);
    chk("R10 tx stops at marked end", vt, 32'h0C);
    chk("R10 tx irq", {31'b0, t_irq}, 32'h1);
    rd(4'd6, v, vt);
    chk("R10 tx saved end", vt, 32'h10);
    rd(4'd1, v, vt);
    chk("R10 plain mode ignores marker", v, 32'h14);
    wr(4'd0, C_RST | C_CLR);
    mem_gnt = 1'b0;
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_regfile();
    t_zero_and_dir();
    t_chained();
    t_unchained();
    t_buserr();
    t_pending_arm();
    t_txmode();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule